// File: doc/BRIEF.md
# Dual-Issue Pairing Checker

This block sits at the issue point of an in-order pipeline that has two unequal execution pipes, U and V. Each cycle it looks at the two oldest decoded instructions and decides how many of them leave. The two candidates are called the older and the younger. If the pair is free of dependences and both fit the pipes, the older goes to U and the younger to V in the same cycle. Otherwise only the older instruction leaves, and the younger one moves into the older slot on the next cycle.

Each candidate presents a valid bit, a set of source register IDs with per-source read enables, a destination register ID with a byte-lane write mask, a two-bit pipe class and a flag that forbids pairing. Pairing is refused on flow dependences and on output dependences. It is also refused when the two instructions write disjoint byte lanes of the same register, because merging those lanes would stall the pipe. A stall from downstream holds everything back. The decision is registered, so the issue outputs describe the inputs seen at the previous clock edge.

Top module: `dual_issue_pair`

## Requirements
- R1: While reset is high and on the first cycle after it, issue_u, issue_v and consumed are all 0.
- R2: With no stall and the older valid, the older instruction always issues. Pipe class encoding is 0 = either pipe, 1 = U only, 2 = V only, 3 = U only. An older instruction of class 2 issues alone in V (issue_u=0, issue_v=1, consumed=1). Any other older instruction issues in U (issue_u=1).
- R3: When a younger source with its read enable set names the older destination and the older write mask is nonzero, the pair is refused (consumed=1). A source with its enable clear, or an older instruction with a zero mask, causes no refusal.
- R4: When both destinations are the same register, both masks are nonzero and the masks share at least one lane, the pair is refused.
- R5: When both destinations are the same register and the masks are nonzero but share no lane (a partial-register write), the pair is refused.
- R6: When the never-pair flag of either instruction is set, the pair is refused.
- R7: The pair is refused when the younger class is 1 or 3, because those classes cannot run in V.
- R8: When both are valid, nothing in R3 to R7 applies and the older class is not 2, the outputs are issue_u=1, issue_v=1, consumed=2.
- R9: A high stall makes the outputs of the next cycle all 0.
- R10: With the older invalid, nothing issues. With only the younger invalid, the older issues alone.
- R11: The outputs are registered. They reflect the inputs present at the previous rising clock edge and do not follow input changes inside a cycle.
- R12: consumed always equals the number of issue outputs that are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | Downstream hold; nothing issues |
| o_valid | input | 1 | Older candidate present |
| o_src | input | NSRC*RW | Older source register IDs, packed |
| o_src_en | input | NSRC | Older source read enables |
| o_dst | input | RW | Older destination register ID |
| o_wmask | input | LANES | Older byte-lane write mask (0 = no write) |
| o_cls | input | 2 | Older pipe class |
| o_solo | input | 1 | Older never-pair flag |
| y_valid | input | 1 | Younger candidate present |
| y_src | input | NSRC*RW | Younger source register IDs, packed |
| y_src_en | input | NSRC | Younger source read enables |
| y_dst | input | RW | Younger destination register ID |
| y_wmask | input | LANES | Younger byte-lane write mask |
| y_cls | input | 2 | Younger pipe class |
| y_solo | input | 1 | Younger never-pair flag |
| issue_u | output | 1 | An instruction enters pipe U |
| issue_v | output | 1 | An instruction enters pipe V |
| consumed | output | 2 | Number of candidates taken this cycle |

## Verification
The assertions check on every cycle that a stall, an invalid older slot, a flow hazard, an overlapping or partial write, a never-pair flag and a V-only older each hold the next cycle's issue below two. They also check that the count always matches the issue bits. Only the bench can show the positive cases: that a clean pair really leaves together, and that a disabled source or a zero mask does not cause a false refusal. The bench also shows that the outputs hold steady inside a cycle, and it compares the whole decision against an independent model over mixed random traffic.

// File: rtl/dual_issue_pkg.sv
package dual_issue_pkg;

    typedef enum logic [1:0] {
        PIPE_ANY  = 2'd0,
        PIPE_U    = 2'd1,
        PIPE_V    = 2'd2,
        PIPE_U_X  = 2'd3
    } pipe_cls_e;

    typedef struct packed {
        logic       to_u;
        logic       to_v;
        logic [1:0] taken;
    } issue_t;

    localparam issue_t ISSUE_NONE = '{to_u: 1'b0, to_v: 1'b0, taken: 2'd0};

    // Class may execute in pipe V.
    function automatic logic fits_v(input logic [1:0] cls);
        return (cls == PIPE_ANY) || (cls == PIPE_V);
    endfunction

    // Class may execute in pipe U.
    function automatic logic fits_u(input logic [1:0] cls);
        return cls != PIPE_V;
    endfunction

endpackage

// File: rtl/dual_issue_hazard.sv
module dual_issue_hazard #(
    parameter int RW    = 3,
    parameter int NSRC  = 2,
    parameter int LANES = 4
) (
    input  logic [RW-1:0]      old_dst,
    input  logic [LANES-1:0]   old_wmask,
    input  logic [NSRC*RW-1:0] yng_src,
    input  logic [NSRC-1:0]    yng_src_en,
    input  logic [RW-1:0]      yng_dst,
    input  logic [LANES-1:0]   yng_wmask,
    output logic               raw,
    output logic               waw,
    output logic               part
);
    logic [NSRC-1:0] src_hit;
    logic            old_writes;
    logic            yng_writes;
    logic            same_dst;
    logic            lane_overlap;

    assign old_writes = |old_wmask;
    assign yng_writes = |yng_wmask;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        assign src_hit[i] = yng_src_en[i] && old_writes &&
                            (yng_src[i*RW +: RW] == old_dst);
    end

    assign raw          = |src_hit;
    assign same_dst     = old_writes && yng_writes && (old_dst == yng_dst);
    assign lane_overlap = |(old_wmask & yng_wmask);
    assign waw          = same_dst && lane_overlap;
    assign part         = same_dst && !lane_overlap;

endmodule

// File: rtl/dual_issue_route.sv
module dual_issue_route
    import dual_issue_pkg::*;
(
    input  logic       stall,
    input  logic       old_valid,
    input  logic [1:0] old_cls,
    input  logic       old_solo,
    input  logic       yng_valid,
    input  logic [1:0] yng_cls,
    input  logic       yng_solo,
    input  logic       blocked,
    output issue_t     nxt
);
    logic pair_ok;

    assign pair_ok = yng_valid && !old_solo && !yng_solo && !blocked &&
                     fits_u(old_cls) && fits_v(yng_cls);

    always_comb begin
        nxt = ISSUE_NONE;
        if (!stall && old_valid) begin
            if (!fits_u(old_cls)) begin
                nxt.to_v  = 1'b1;
                nxt.taken = 2'd1;
            end else if (pair_ok) begin
                nxt.to_u  = 1'b1;
                nxt.to_v  = 1'b1;
                nxt.taken = 2'd2;
            end else begin
                nxt.to_u  = 1'b1;
                nxt.taken = 2'd1;
            end
        end
    end

endmodule

// File: rtl/dual_issue_pair.sv
module dual_issue_pair
    import dual_issue_pkg::*;
#(
    parameter int NREGS = 8,
    parameter int NSRC  = 2,
    parameter int LANES = 4,
    localparam int RW   = $clog2(NREGS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               stall,
    input  logic               o_valid,
    input  logic [NSRC*RW-1:0] o_src,
    input  logic [NSRC-1:0]    o_src_en,
    input  logic [RW-1:0]      o_dst,
    input  logic [LANES-1:0]   o_wmask,
    input  logic [1:0]         o_cls,
    input  logic               o_solo,
    input  logic               y_valid,
    input  logic [NSRC*RW-1:0] y_src,
    input  logic [NSRC-1:0]    y_src_en,
    input  logic [RW-1:0]      y_dst,
    input  logic [LANES-1:0]   y_wmask,
    input  logic [1:0]         y_cls,
    input  logic               y_solo,
    output logic               issue_u,
    output logic               issue_v,
    output logic [1:0]         consumed
);
    logic   hz_raw;
    logic   hz_waw;
    logic   hz_part;
    issue_t nxt;
    issue_t q;

    // Older sources are unused here; they matter only to later stages.
    logic unused_old_src;
    assign unused_old_src = ^{o_src, o_src_en};

    dual_issue_hazard #(.RW(RW), .NSRC(NSRC), .LANES(LANES)) u_hazard (
        .old_dst    (o_dst),
        .old_wmask  (o_wmask),
        .yng_src    (y_src),
        .yng_src_en (y_src_en),
        .yng_dst    (y_dst),
        .yng_wmask  (y_wmask),
        .raw        (hz_raw),
        .waw        (hz_waw),
        .part       (hz_part)
    );

    dual_issue_route u_route (
        .stall     (stall),
        .old_valid (o_valid),
        .old_cls   (o_cls),
        .old_solo  (o_solo),
        .yng_valid (y_valid),
        .yng_cls   (y_cls),
        .yng_solo  (y_solo),
        .blocked   (hz_raw || hz_waw || hz_part),
        .nxt       (nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) q <= ISSUE_NONE;
        else     q <= nxt;
    end

    assign issue_u  = q.to_u;
    assign issue_v  = q.to_v;
    assign consumed = q.taken;

    AST_STALL_IDLE: assert property (@(posedge clk) disable iff (rst)
        stall |=> (!issue_u && !issue_v)) else $error("stall leak"); // R9
    AST_NO_OLDER: assert property (@(posedge clk) disable iff (rst)
        !o_valid |=> (consumed == 2'd0)) else $error("issue without older"); // R10
    AST_RAW_SPLIT: assert property (@(posedge clk) disable iff (rst)
        hz_raw |=> (consumed != 2'd2)) else $error("paired across flow dep"); // R3
    AST_WAW_SPLIT: assert property (@(posedge clk) disable iff (rst)
        hz_waw |=> (consumed != 2'd2)) else $error("paired across output dep"); // R4
    AST_PART_SPLIT: assert property (@(posedge clk) disable iff (rst)
        hz_part |=> (consumed != 2'd2)) else $error("paired partial write"); // R5
    AST_SOLO_SPLIT: assert property (@(posedge clk) disable iff (rst)
        (o_solo || y_solo) |=> (consumed != 2'd2)) else $error("never-pair paired"); // R6
    AST_VONLY_OLDER: assert property (@(posedge clk) disable iff (rst)
        (!stall && o_valid && o_cls == 2'd2) |=> (issue_v && !issue_u)) else $error("V-only older misrouted"); // R2
    AST_COUNT_MATCH: assert property (@(posedge clk) disable iff (rst)
        consumed == ({1'b0, issue_u} + {1'b0, issue_v})) else $error("count mismatch"); // R12

endmodule

// File: tb/sim_dual_issue_pair.sv
module sim_dual_issue_pair;
    localparam int NREGS = 8;
    localparam int NSRC  = 2;
    localparam int LANES = 4;
    localparam int RW    = 3;

    logic clk = 1'b0;
    logic rst;
    logic stall;
    logic o_valid, y_valid, o_solo, y_solo;
    logic [NSRC*RW-1:0] o_src, y_src;
    logic [NSRC-1:0] o_src_en, y_src_en;
    logic [RW-1:0] o_dst, y_dst;
    logic [LANES-1:0] o_wmask, y_wmask;
    logic [1:0] o_cls, y_cls;
    logic issue_u, issue_v;
    logic [1:0] consumed;

    int n_checks = 0;
    int n_fail   = 0;
    logic [3:0] expv;

    always #2 clk = ~clk;

    dual_issue_pair #(.NREGS(NREGS), .NSRC(NSRC), .LANES(LANES)) u0 (
        .clk(clk), .rst(rst), .stall(stall),
        .o_valid(o_valid), .o_src(o_src), .o_src_en(o_src_en), .o_dst(o_dst),
        .o_wmask(o_wmask), .o_cls(o_cls), .o_solo(o_solo),
        .y_valid(y_valid), .y_src(y_src), .y_src_en(y_src_en), .y_dst(y_dst),
        .y_wmask(y_wmask), .y_cls(y_cls), .y_solo(y_solo),
        .issue_u(issue_u), .issue_v(issue_v), .consumed(consumed)
    );

    // Independent model of the requirements: returns {u, v, count}.
    function automatic logic [3:0] model();
        logic flow, clash, pair;
        flow = 1'b0;
        for (int i = 0; i < NSRC; i++)
            if (y_src_en[i] && o_wmask != 0 && y_src[i*RW +: RW] == o_dst) flow = 1'b1;
        clash = (o_wmask != 0) && (y_wmask != 0) && (o_dst == y_dst);
        pair  = y_valid && !flow && !clash && !o_solo && !y_solo &&
                (y_cls == 2'd0 || y_cls == 2'd2);
        if (stall || !o_valid) return 4'b0000;
        if (o_cls == 2'd2)     return 4'b0101;
        if (pair)              return 4'b1110;
        return 4'b1001;
    endfunction

    task automatic check(input string rq, input logic [3:0] exp_v);
        logic [3:0] got;
        got = {issue_u, issue_v, consumed};
        n_checks++;
        if (got !== exp_v) begin
            n_fail++;
            $display("FAIL %s: got u/v/cnt=%b expected %b", rq, got, exp_v);
        end
    endtask

    // Inputs are applied just after a falling edge; results are read at the next one.
    task automatic step(input string rq);
        expv = model();
        @(negedge clk);
        check(rq, expv);
    endtask

    task automatic base();
        stall = 0;
        o_valid = 1; y_valid = 1; o_solo = 0; y_solo = 0;
        o_src = {3'd5, 3'd6}; y_src = {3'd3, 3'd4};
        o_src_en = 2'b11; y_src_en = 2'b11;
        o_dst = 3'd1; y_dst = 3'd2;
        o_wmask = 4'b0001; y_wmask = 4'b0001;
        o_cls = 2'd0; y_cls = 2'd0;
    endtask

    initial begin : watchdog
        #400000;
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        base();
        rst = 1;
        repeat (3) @(negedge clk);
        check("R1", 4'b0000);
        rst = 0;
        check("R1", 4'b0000);

        base(); step("R8");
        base(); y_src[2:0] = 3'd1; step("R3");
        base(); y_src[5:3] = 3'd1; y_src_en = 2'b01; step("R3");
        base(); y_src[2:0] = 3'd1; o_wmask = 4'b0000; step("R3");
        base(); y_dst = 3'd1; step("R4");
        base(); y_dst = 3'd1; o_wmask = 4'b0011; y_wmask = 4'b0110; step("R4");
        base(); y_dst = 3'd1; o_wmask = 4'b0001; y_wmask = 4'b0010; step("R5");
        base(); y_dst = 3'd1; o_wmask = 4'b1100; y_wmask = 4'b0011; step("R5");
        base(); o_solo = 1; step("R6");
        base(); y_solo = 1; step("R6");
        base(); o_cls = 2'd2; step("R2");
        base(); o_cls = 2'd1; step("R2");
        base(); y_cls = 2'd1; step("R7");
        base(); y_cls = 2'd3; step("R7");
        base(); y_cls = 2'd2; step("R7");
        base(); stall = 1; step("R9");
        base(); o_valid = 0; step("R10");
        base(); y_valid = 0; step("R10");

        // R11: a mid-cycle change must not show before the next edge.
        base(); step("R11");
        o_valid = 0;
        #1;
        check("R11", 4'b1110);
        @(negedge clk);
        check("R11", 4'b0000);

        for (int k = 0; k < 400; k++) begin
            stall    = ($urandom % 8) == 0;
            o_valid  = ($urandom % 8) != 0;
            y_valid  = ($urandom % 6) != 0;
            o_src    = {3'($urandom % 4), 3'($urandom % 4)};
            y_src    = {3'($urandom % 4), 3'($urandom % 4)};
            o_src_en = 2'($urandom);
            y_src_en = 2'($urandom);
            o_dst    = 3'($urandom % 4);
            y_dst    = 3'($urandom % 4);
            o_wmask  = 4'($urandom);
            y_wmask  = 4'($urandom);
            o_cls    = 2'($urandom);
            y_cls    = 2'($urandom);
            o_solo   = ($urandom % 6) == 0;
            y_solo   = ($urandom % 6) == 0;
            step("R8 random");
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule